// File: doc/BRIEF.md
# Indirect Coefficient RAM Access Port

This block puts a narrow byte-wide register bus in front of a 62-entry RAM of 24-bit filter coefficients. Software never addresses the RAM directly. It loads an index register and fills a bank of fifteen byte staging registers, which hold five coefficients of three bytes each. It then writes a command into a control register. The command moves either one coefficient or a whole five-coefficient biquad set between the staging bank and the RAM, and the command bits then clear themselves.

A second, read-only port lets the filter datapath fetch any coefficient every cycle. A biquad set is committed to the RAM on a single clock edge. The datapath port therefore sees either the complete old set or the complete new set, and never a mix of the two. A transfer that would run past the last entry is dropped and raises a sticky error flag.

Top module: `coef_port`

## Requirements
- R1: After reset, entries 4, 9, 14, …, 49 (every index i < 50 with i mod 5 = 4) hold 0x400000. Entries 50 to 54, 56 and 59 hold 0x7FFFFF. Entry 55 holds 0x5A9DF7, and entries 60 and 61 hold 0x400000. Every other entry holds 0.
- R2: The register map places the index register at bus address 0x00, with 6 bits that read back zero-extended. Staging byte j (0..14) sits at address 0x01+j. Coefficient k of the bank occupies bytes 3k, 3k+1 and 3k+2, most significant byte first. Read data appears on `busRdata` one clock after the read strobe.
- R3: Writing the control register (address 0x10) with bit 0 set (0x01) stores {byte0, byte1, byte2} in the RAM entry selected by the index register.
- R4: Control bit 1 (0x02) stores staging coefficient k in entry index+k for k = 0..4, with all five written on the same clock edge.
- R5: Control bit 3 (0x08) loads entries index..index+4 into the five staging coefficients. Control bit 2 (0x04) loads only coefficient 0 (bytes 0..2) and leaves bytes 3..14 untouched.
- R6: A command executes on the clock edge after the control write. `busy` is high for exactly that one cycle, and the control register then reads back zero.
- R7: Bits 7..4 of the control register always read 0, whatever value was written.
- R8: A five-coefficient command with index > 57, or a single-coefficient command with index > 61, changes neither the RAM nor the staging bytes. It sets `errFlag`, which stays high until reset.
- R9: `dpData` returns the entry selected by `dpAddr` one clock later, or 0 when `dpAddr` > 61.
- R10: If several command bits are written together, only the lowest-numbered set bit executes.
- R11: Bus writes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Register bus address |
| busWdata | input | 8 | Register bus write data |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busRdata | output | 8 | Registered read data |
| busy | output | 1 | Transfer executing this cycle |
| errFlag | output | 1 | Sticky out-of-range transfer flag |
| dpAddr | input | 6 | Datapath coefficient index |
| dpData | output | 24 | Datapath coefficient, one cycle after `dpAddr` |

## Verification
A control write taken on edge N shows `busy` in the cycle after N. The RAM or staging update lands on edge N+1, so the bench samples `busy` at the falling edge after the write and again one cycle later. Bus reads and datapath reads each have one register stage. The bench drives the strobe or index at a falling edge and compares `busRdata` or `dpData` at the next falling edge. Results of a command are only checked through accesses that start after the busy cycle, and the bench model is updated at that same point.

// File: rtl/coef_pkg.sv
package coef_pkg;

  // Strobes from control to datapath, at most one transfer flag set per cycle.
  typedef struct packed {
    logic wrOne;
    logic wrSet;
    logic rdOne;
    logic rdSet;
    logic fault;
  } coefStrobe_t;

  // Power-on content of one coefficient entry.
  function automatic logic [23:0] coefResetVal(input int idx);
    if (idx < 50) return (idx % 5 == 4) ? 24'h400000 : 24'h000000;
    if (idx <= 54) return 24'h7FFFFF;
    case (idx)
      55:      return 24'h5A9DF7;
      56, 59:  return 24'h7FFFFF;
      60, 61:  return 24'h400000;
      default: return 24'h000000;
    endcase
  endfunction

endpackage

// File: rtl/coef_ctrl.sv
module coef_ctrl
  import coef_pkg::*;
#(
  parameter int N_COEF  = 62,
  parameter int SET_LEN = 5,
  parameter int AW      = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWe,
  input  logic [3:0]    ctrlWdata,
  input  logic [AW-1:0] coefAddr,
  output logic [3:0]    cmdBits,
  output logic          busy,
  output logic          errFlag,
  output coefStrobe_t   strb
);
  localparam int LAST_ONE = N_COEF - 1;
  localparam int LAST_SET = N_COEF - SET_LEN;

  logic [3:0] cmd;
  logic [3:0] lowBit;
  logic       okOne;
  logic       okSet;

  // Command register: loaded by a host write, cleared after its one busy cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cmd <= '0;
    else if (busy)   cmd <= '0;
    else if (ctrlWe) cmd <= ctrlWdata;
  end

  assign busy    = |cmd;
  assign cmdBits = cmd;

  always_comb begin
    lowBit     = cmd & (~cmd + 4'd1);
    okOne      = int'(coefAddr) <= LAST_ONE;
    okSet      = int'(coefAddr) <= LAST_SET;
    strb.wrOne = lowBit[0] & okOne;
    strb.wrSet = lowBit[1] & okSet;
    strb.rdOne = lowBit[2] & okOne;
    strb.rdSet = lowBit[3] & okSet;
    strb.fault = ((lowBit[0] | lowBit[2]) & !okOne) |
                 ((lowBit[1] | lowBit[3]) & !okSet);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           errFlag <= 1'b0;
    else if (strb.fault) errFlag <= 1'b1;
  end

endmodule

// File: rtl/coef_dp.sv
module coef_dp
  import coef_pkg::*;
#(
  parameter int N_COEF  = 62,
  parameter int COEF_W  = 24,
  parameter int SET_LEN = 5,
  parameter int AW      = 6,
  parameter int BW      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  coefStrobe_t       strb,
  input  logic              busy,
  input  logic [3:0]        cmdBits,
  input  logic [BW-1:0]     busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        busRdata,
  output logic [AW-1:0]     coefAddr,
  input  logic [AW-1:0]     dpAddr,
  output logic [COEF_W-1:0] dpData
);
  localparam int NBYTE     = COEF_W / 8;
  localparam int NSTAGE    = SET_LEN * NBYTE;
  localparam int CTRL_ADDR = NSTAGE + 1;

  logic [7:0]                stage [NSTAGE];
  logic [COEF_W-1:0]         ram [N_COEF];
  logic [SET_LEN*COEF_W-1:0] stagedFlat;
  logic [COEF_W-1:0]         fetchWord [SET_LEN];
  logic [7:0]                rdMux;
  logic                      hostWr;

  assign hostWr = busWr && !busy;

  // Staging bytes assembled into coefficients, most significant byte first.
  generate
    for (genvar k = 0; k < SET_LEN; k++) begin : g_coef
      for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign stagedFlat[k*COEF_W + (NBYTE-1-b)*8 +: 8] = stage[k*NBYTE + b];
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < SET_LEN; k++) begin
      fetchWord[k] = '0;
      for (int e = 0; e < N_COEF; e++)
        if (int'(coefAddr) + k == e) fetchWord[k] = ram[e];
    end
  end

  // Coefficient RAM: a whole set lands on one edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < N_COEF; e++) ram[e] <= COEF_W'(coefResetVal(e));
    end else begin
      for (int e = 0; e < N_COEF; e++)
        for (int k = 0; k < SET_LEN; k++)
          if ((strb.wrSet || (strb.wrOne && k == 0)) && int'(coefAddr) + k == e)
            ram[e] <= stagedFlat[k*COEF_W +: COEF_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSTAGE; i++) stage[i] <= '0;
    end else begin
      for (int i = 0; i < NSTAGE; i++)
        if (hostWr && int'(busAddr) == i + 1) stage[i] <= busWdata;
      for (int k = 0; k < SET_LEN; k++)
        for (int b = 0; b < NBYTE; b++)
          if (strb.rdSet || (strb.rdOne && k == 0))
            stage[k*NBYTE + b] <= fetchWord[k][COEF_W-1-8*b -: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        coefAddr <= '0;
    else if (hostWr && busAddr == '0) coefAddr <= busWdata[AW-1:0];
  end

  always_comb begin
    rdMux = '0;
    if (int'(busAddr) == 0)              rdMux = 8'(coefAddr);
    else if (int'(busAddr) == CTRL_ADDR) rdMux = {4'h0, cmdBits};
    else
      for (int i = 0; i < NSTAGE; i++)
        if (int'(busAddr) == i + 1) rdMux = stage[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= rdMux;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dpData <= '0;
    else       dpData <= (int'(dpAddr) < N_COEF) ? ram[dpAddr] : '0;
  end

endmodule

// File: rtl/coef_port.sv
module coef_port
  import coef_pkg::*;
#(
  parameter int  N_COEF  = 62,
  parameter int  COEF_W  = 24,
  parameter int  SET_LEN = 5,
  localparam int AW      = $clog2(N_COEF),
  localparam int NSTAGE  = SET_LEN * (COEF_W / 8),
  localparam int BW      = $clog2(NSTAGE + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BW-1:0]     busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        busRdata,
  output logic              busy,
  output logic              errFlag,
  input  logic [AW-1:0]     dpAddr,
  output logic [COEF_W-1:0] dpData
);
  localparam int CTRL_ADDR = NSTAGE + 1;

  coefStrobe_t   strb;
  logic [3:0]    cmdBits;
  logic [AW-1:0] coefAddr;
  logic          ctrlWe;

  assign ctrlWe = busWr && !busy && int'(busAddr) == CTRL_ADDR;

  coef_ctrl #(.N_COEF(N_COEF), .SET_LEN(SET_LEN), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(busWdata[3:0]),
    .coefAddr(coefAddr), .cmdBits(cmdBits), .busy(busy),
    .errFlag(errFlag), .strb(strb)
  );

  coef_dp #(.N_COEF(N_COEF), .COEF_W(COEF_W), .SET_LEN(SET_LEN), .AW(AW), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .cmdBits(cmdBits),
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .busRdata(busRdata), .coefAddr(coefAddr), .dpAddr(dpAddr), .dpData(dpData)
  );

endmodule

// File: rtl/coef_port_chk.sv
module coef_port_chk #(
  parameter int N_COEF    = 62,
  parameter int COEF_W    = 24,
  parameter int AW        = 6,
  parameter int BW        = 5,
  parameter int CTRL_ADDR = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [BW-1:0]     busAddr,
  input logic              busRd,
  input logic [7:0]        busRdata,
  input logic              busy,
  input logic              errFlag,
  input logic [AW-1:0]     dpAddr,
  input logic [COEF_W-1:0] dpData
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && int'(busAddr) == CTRL_ADDR) |=> busRdata[7:4] == 4'h0); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R8

  AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(busy)); // R8

  AST_DP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(dpAddr) >= N_COEF) |=> dpData == '0); // R9

  AST_DP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && !$past(busy) && $stable(dpAddr)) |=> $stable(dpData)); // R4

endmodule

bind coef_port coef_port_chk #(
  .N_COEF(N_COEF), .COEF_W(COEF_W), .AW(AW), .BW(BW), .CTRL_ADDR(NSTAGE + 1)
) u_chk (.*);

// File: tb/coef_port_tb.sv
`timescale 1ns/1ps
module coef_port_tb;
  localparam int CTRL = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdata;
  logic        busy;
  logic        errFlag;
  logic [5:0]  dpAddr = '0;
  logic [23:0] dpData;

  int nChk = 0;
  int nErr = 0;

  logic [23:0] mRam [62];
  logic [7:0]  mStage [15];
  logic [5:0]  mAddr;
  logic        mErr;

  coef_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata), .busy(busy),
    .errFlag(errFlag), .dpAddr(dpAddr), .dpData(dpData)
  );

  always #2.5 clk = ~clk;

  function automatic logic [23:0] expReset(input int i);
    if (i == 55) return 24'h5A9DF7;
    if ((i >= 50 && i <= 54) || i == 56 || i == 59) return 24'h7FFFFF;
    if (i == 60 || i == 61) return 24'h400000;
    if (i < 50 && (i % 5) == 4) return 24'h400000;
    return 24'h0;
  endfunction

  function automatic logic [23:0] stWord(input int k);
    return {mStage[3*k], mStage[3*k+1], mStage[3*k+2]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [7:0] d);
    busAddr = 5'(a); busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [7:0] d);
    busAddr = 5'(a); busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic setStage(input int j, input logic [7:0] d);
    busWrite(j + 1, d);
    mStage[j] = d;
  endtask

  task automatic setAddr(input logic [5:0] a);
    busWrite(0, {2'b00, a});
    mAddr = a;
  endtask

  // Update the model for one command, lowest set bit first (R10).
  task automatic applyCmd(input logic [3:0] c);
    logic [3:0] low;
    logic okOne, okSet;
    low = c & (~c + 4'd1);
    okOne = mAddr <= 6'd61;
    okSet = mAddr <= 6'd57;
    if (low[0]) begin if (okOne) mRam[mAddr] = stWord(0); else mErr = 1'b1; end
    if (low[1]) begin
      if (okSet) for (int k = 0; k < 5; k++) mRam[int'(mAddr)+k] = stWord(k);
      else mErr = 1'b1;
    end
    if (low[2]) begin
      if (okOne) {mStage[0], mStage[1], mStage[2]} = mRam[mAddr];
      else mErr = 1'b1;
    end
    if (low[3]) begin
      if (okSet) for (int k = 0; k < 5; k++)
        {mStage[3*k], mStage[3*k+1], mStage[3*k+2]} = mRam[int'(mAddr)+k];
      else mErr = 1'b1;
    end
  endtask

  task automatic doCmd(input logic [7:0] c);
    busWrite(CTRL, c);
    chk("R6 busy during transfer", 32'(busy), 32'(c[3:0] != 4'h0));
    @(negedge clk);
    chk("R6 busy cleared", 32'(busy), 0);
    applyCmd(c[3:0]);
  endtask

  task automatic dpCheck(input int a, input string tag);
    dpAddr = 6'(a);
    @(negedge clk);
    chk(tag, 32'(dpData), (a < 62) ? 32'(mRam[a]) : 0);
  endtask

  task automatic stageCheck(input int j, input string tag);
    logic [7:0] d;
    busRead(j + 1, d);
    chk(tag, 32'(d), 32'(mStage[j]));
  endtask

  initial begin
    #(5.0 * 150000);
    nErr++;
    $display("FAIL R6 watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 62; i++) mRam[i] = expReset(i);
    for (int j = 0; j < 15; j++) mStage[j] = '0;
    mAddr = '0; mErr = 1'b0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state.
    chk("R6 busy at reset", 32'(busy), 0);
    chk("R8 err at reset", 32'(errFlag), 0);
    busRead(CTRL, d); chk("R7 ctrl at reset", 32'(d), 0);
    busRead(0, d);    chk("R2 addr at reset", 32'(d), 0);
    for (int i = 0; i < 64; i++) dpCheck(i, "R1 R9 reset content");

    // Staging map and single write.
    for (int j = 0; j < 15; j++) setStage(j, 8'(8'h11 * (j + 1)));
    for (int j = 0; j < 15; j++) stageCheck(j, "R2 staging readback");
    setAddr(6'd37);
    busRead(0, d); chk("R2 addr readback", 32'(d), 37);
    setAddr(6'd20);
    doCmd(8'h01);
    dpCheck(20, "R3 single write");
    dpCheck(21, "R3 neighbour untouched");

    // Biquad set write.
    setAddr(6'd10);
    doCmd(8'h02);
    for (int i = 9; i < 16; i++) dpCheck(i, "R4 set write");

    // Set read at the last legal index, then single read.
    setAddr(6'd57);
    doCmd(8'h08);
    for (int j = 0; j < 15; j++) stageCheck(j, "R5 set read");
    setStage(4, 8'h55);
    setAddr(6'd50);
    doCmd(8'h04);
    for (int j = 0; j < 6; j++) stageCheck(j, "R5 single read");

    // Priority and reserved bits.
    setAddr(6'd55);
    doCmd(8'h0C);
    for (int j = 0; j < 6; j++) stageCheck(j, "R10 lowest bit wins");
    doCmd(8'hF0);
    busRead(CTRL, d); chk("R7 reserved only", 32'(d), 0);
    setAddr(6'd30);
    doCmd(8'hF6);
    busRead(CTRL, d); chk("R7 ctrl after cmd", 32'(d), 0);
    for (int i = 30; i < 35; i++) dpCheck(i, "R10 R4 set from 0xF6");
    chk("R8 err still low", 32'(errFlag), 0);

    // Out-of-range transfers.
    setAddr(6'd58);
    doCmd(8'h02);
    chk("R8 err set", 32'(errFlag), 1);
    for (int i = 58; i < 62; i++) dpCheck(i, "R8 RAM untouched");
    setAddr(6'd60);
    doCmd(8'h08);
    for (int j = 0; j < 15; j++) stageCheck(j, "R8 staging untouched");
    setAddr(6'd62);
    doCmd(8'h01);
    setAddr(6'd61);
    doCmd(8'h01);
    dpCheck(61, "R8 single at last entry");
    chk("R8 err sticky", 32'(errFlag), 1);

    // Writes during the busy cycle are dropped.
    setAddr(6'd5);
    busWrite(CTRL, 8'h01);
    busWrite(1, 8'hAA);
    applyCmd(4'h1);
    busWrite(CTRL, 8'h01);
    busWrite(0, 8'h03);
    applyCmd(4'h1);
    stageCheck(0, "R11 staging write dropped");
    busRead(0, d); chk("R11 addr write dropped", 32'(d), 32'(mAddr));
    dpCheck(5, "R11 command still ran");

    // Random mix.
    for (int n = 0; n < 600; n++) begin
      case ($urandom % 7)
        0, 1: setStage(int'($urandom % 15), 8'($urandom));
        2:    setAddr(6'(($urandom % 4 == 0) ? $urandom : $urandom % 58));
        3:    doCmd(8'($urandom));
        4:    stageCheck(int'($urandom % 15), "R5 random staging");
        5:    dpCheck(int'($urandom % 64), "R4 R9 random datapath");
        default: begin
          busRead(0, d); chk("R2 random addr", 32'(d), 32'(mAddr));
        end
      endcase
    end
    chk("R8 random err", 32'(errFlag), 32'(mErr));
    for (int i = 0; i < 62; i++) dpCheck(i, "R3 R4 final content");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule